// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked on-chip requester and an external asynchronous static RAM of 32K words by 16 bits. The requester offers one access at a time over a valid/ready port, carrying a write flag, a word address, write data and a two-bit byte mask. The block turns each access into the strobe pattern the memory expects. It drives active-low chip enable, output enable, write enable and the two byte selects. It also drives the address bus and the outgoing half of the data bus together with its tri-state enable.

The memory's nanosecond limits become whole clock cycles, each set by a parameter. These are the address-to-strobe setup, the write pulse width, the data hold after the write edge, the read access window and the bus turnaround after a read. A write is captured by the memory on the rising edge of write enable. The block keeps its data driver on through that edge and for the hold time after it. A read keeps output enable low for the whole access window and registers the bus in the window's last cycle. An access whose byte mask is all zero finishes in one cycle without touching the memory.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip enable, output enable, write enable and both byte selects are high, `sram_dq_oe` is 0, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after a nonzero-mask request is taken until its access ends: after T_SETUP+T_WP+T_HOLD cycles for a write, and after T_RD+T_TURN cycles for a read.
- R3: In a write, chip enable is low with write enable high for exactly T_SETUP cycles. Write enable is then low for exactly T_WP cycles. The data driver stays on from the fall of write enable until T_HOLD cycles after its rise, and `sram_dq_out` does not change while it is on.
- R4: Mask bit 0 selects data bits 7:0 through `sram_lb_n` and mask bit 1 selects bits 15:8 through `sram_ub_n`, each select being low only when its mask bit is 1. A write changes only the selected bytes of the addressed word.
- R5: In a read, chip enable and output enable are low and write enable is high for exactly T_RD cycles. `rd_data` holds the bus as sampled in the last of those cycles, with unselected bytes forced to zero, and `rd_valid` is 1 for the single cycle that follows.
- R6: The data driver is never on while output enable is low, and write enable and output enable are never low together.
- R7: The address bus does not change in any cycle where chip enable was low in the previous cycle and is still low.
- R8: After a read, chip enable and output enable stay high and no new request is taken for T_TURN cycles.
- R9: A request with a mask of zero is taken without any strobe going low. `req_ready` is 1 again in the next cycle. For a read, `rd_valid` is 1 in the next cycle with `rd_data` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte mask, bit 0 for bits 7:0, bit 1 for bits 15:8 |
| req_ready | output | 1 | Block can take a request |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| sram_addr | output | 15 | Memory address bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_lb_n | output | 1 | Low byte select, active low |
| sram_ub_n | output | 1 | High byte select, active low |
| sram_dq_out | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Tri-state enable for `sram_dq_out` |
| sram_dq_in | input | 16 | Data seen on the memory bus |

## Verification
The assertions assume that every timing parameter is at least 1 and that the requester holds its request fields steady while `req_valid` waits for `req_ready`. They also assume the memory's own response is settled within one clock cycle of the strobes. The stimulus drives requests only at falling edges and holds them until the handshake is seen. It also uses a bench memory model that answers the strobes at once and stores data on the rising edge of write enable. The random traffic covers all four mask values, both directions and a pool of addresses at both ends of the address range. This mix forces partial-byte overwrites and zero-mask requests between real accesses.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC,
        ST_RTURN
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
        logic lanes_on;
    } strobe_t;

    function automatic strobe_t strobes_for(phase_e p);
        strobe_t s;
        s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0, lanes_on: 1'b0};
        case (p)
            ST_WSETUP: s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0, lanes_on: 1'b1};
            ST_WPULSE: s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1, lanes_on: 1'b1};
            ST_WHOLD:  s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1, lanes_on: 1'b1};
            ST_RACC:   s = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0, lanes_on: 1'b1};
            default:   s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0, lanes_on: 1'b0};
        endcase
        return s;
    endfunction

    function automatic int span_bits(int a, int b, int c, int d, int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return $clog2(m + 1) + 1;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    a_r3_timer_counts_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/asram_byte_lanes.sv
module asram_byte_lanes #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0]   mask_next,
    input  logic               lanes_on_next,
    input  logic [LANES-1:0]   mask_cur,
    input  logic [8*LANES-1:0] bus_in,
    output logic [LANES-1:0]   sel_n_next,
    output logic [8*LANES-1:0] rd_bytes
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sel_n_next[i]     = !(lanes_on_next && mask_next[i]);
        assign rd_bytes[8*i +: 8] = mask_cur[i] ? bus_in[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
    parameter int AW      = 15,
    parameter int DW      = 16,
    parameter int T_SETUP = 1,
    parameter int T_WP    = 1,
    parameter int T_HOLD  = 1,
    parameter int T_RD    = 2,
    parameter int T_TURN  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_bmask,
    output logic          req_ready,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic          sram_lb_n,
    output logic          sram_ub_n,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in
);
    import asram_pkg::*;

    localparam int LANES = DW / 8;
    localparam int CW    = span_bits(T_SETUP, T_WP, T_HOLD, T_RD, T_TURN);

    phase_e            state, state_n;
    strobe_t           strb_q, strb_n;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [LANES-1:0]  mask_q, mask_n, sel_n_next, sel_q;
    logic [DW-1:0]     rd_bytes;
    logic              accept, zero_req, expired, tmr_load;
    logic [CW-1:0]     tmr_val;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign zero_req  = accept && (req_bmask == '0);
    assign mask_n    = accept ? LANES'(req_bmask) : mask_q;

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:   if (accept && !zero_req) state_n = req_write ? ST_WSETUP : ST_RACC;
            ST_WSETUP: if (expired) state_n = ST_WPULSE;
            ST_WPULSE: if (expired) state_n = ST_WHOLD;
            ST_WHOLD:  if (expired) state_n = ST_IDLE;
            ST_RACC:   if (expired) state_n = ST_RTURN;
            ST_RTURN:  if (expired) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        case (state_n)
            ST_WSETUP: tmr_val = CW'(T_SETUP - 1);
            ST_WPULSE: tmr_val = CW'(T_WP - 1);
            ST_WHOLD:  tmr_val = CW'(T_HOLD - 1);
            ST_RACC:   tmr_val = CW'(T_RD - 1);
            ST_RTURN:  tmr_val = CW'(T_TURN - 1);
            default:   tmr_val = '0;
        endcase
    end
    assign tmr_load = (state_n != state);
    assign strb_n   = strobes_for(state_n);

    asram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    asram_byte_lanes #(.LANES(LANES)) u_lanes (
        .mask_next     (mask_n),
        .lanes_on_next (strb_n.lanes_on),
        .mask_cur      (mask_q),
        .bus_in        (sram_dq_in),
        .sel_n_next    (sel_n_next),
        .rd_bytes      (rd_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            strb_q   <= strobes_for(ST_IDLE);
            sel_q    <= '1;
            addr_q   <= '0;
            wdata_q  <= '0;
            mask_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            state  <= state_n;
            strb_q <= strb_n;
            sel_q  <= sel_n_next;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= LANES'(req_bmask);
            end
            if (state == ST_RACC && expired) begin
                rd_data  <= rd_bytes;
                rd_valid <= 1'b1;
            end else if (zero_req && !req_write) begin
                rd_data  <= '0;
                rd_valid <= 1'b1;
            end else begin
                rd_valid <= 1'b0;
            end
        end
    end

    assign sram_addr   = addr_q;
    assign sram_ce_n   = strb_q.ce_n;
    assign sram_oe_n   = strb_q.oe_n;
    assign sram_we_n   = strb_q.we_n;
    assign sram_dq_oe  = strb_q.drive;
    assign sram_dq_out = wdata_q;
    assign sram_lb_n   = sel_q[0];
    assign sram_ub_n   = sel_q[LANES-1];

    // Checker state: length of the current write-enable low pulse
    logic [CW-1:0] we_lo_cnt;
    always_ff @(posedge clk) begin
        if (rst)             we_lo_cnt <= '0;
        else if (!sram_we_n) we_lo_cnt <= we_lo_cnt + 1'b1;
        else                 we_lo_cnt <= '0;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (sram_ce_n && sram_oe_n && sram_we_n && sram_lb_n && sram_ub_n && !sram_dq_oe && !rd_valid));
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> !req_ready);
    a_r3_wp_width: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_lo_cnt == CW'(T_WP)));
    a_r3_data_held_at_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (sram_dq_oe && $stable(sram_dq_out) && !sram_ce_n));
    a_r6_no_drive_with_oe: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n);
    a_r6_we_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> sram_oe_n);
    a_r7_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
    a_r8_turn_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (!sram_dq_oe && !req_ready));
    a_r9_zero_mask_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_bmask == 2'b00) |=> (sram_ce_n && req_ready));
endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
    localparam int AW = 15, DW = 16;
    localparam int TS = 2, TW = 3, TH = 1, TR = 3, TT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] req_bmask = '0;
    logic req_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    logic sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out, sram_dq_in;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    asram_ctrl #(.AW(AW), .DW(DW), .T_SETUP(TS), .T_WP(TW), .T_HOLD(TH),
                 .T_RD(TR), .T_TURN(TT)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
        .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in));

    // Memory model and reference contents
    logic [DW-1:0] mem [int];
    logic [DW-1:0] refm [int];

    function automatic logic [DW-1:0] ref_rd(int a);
        return refm.exists(a) ? refm[a] : '0;
    endfunction

    function automatic logic [DW-1:0] lane_mask(logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    always @* begin
        logic [DW-1:0] w;
        w = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : '0;
        sram_dq_in = 16'hA5A5;
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            if (!sram_lb_n) sram_dq_in[7:0]  = w[7:0];
            if (!sram_ub_n) sram_dq_in[15:8] = w[15:8];
        end
    end

    always @(posedge sram_we_n) begin
        if (!rst && sram_ce_n === 1'b0 && sram_dq_oe === 1'b1) begin
            logic [DW-1:0] w;
            w = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : '0;
            if (!sram_lb_n) w[7:0]  = sram_dq_out[7:0];
            if (!sram_ub_n) w[15:8] = sram_dq_out[15:8];
            mem[int'(sram_addr)] = w;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Strobe timing monitor, sampled at falling edges
    int setup_cnt = 0, wlo_cnt = 0, hold_cnt = 0;
    logic p_we = 1, p_ce = 1, p_oe_drv = 0;
    logic [AW-1:0] p_addr = '0;
    bit ce_seen = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!sram_ce_n) ce_seen = 1;
            if (p_we && !sram_we_n) chk("R3 setup cycles", setup_cnt, TS);
            if (!p_we && sram_we_n) chk("R3 write pulse cycles", wlo_cnt, TW);
            if (p_oe_drv && !sram_dq_oe) chk("R3 hold cycles", hold_cnt, TH);
            if (sram_dq_oe) chk("R6 driver while output enable low", sram_oe_n, 1);
            if (!sram_we_n) chk("R6 write and output enable together", sram_oe_n, 1);
            if (!p_ce && !sram_ce_n) chk("R7 address moved under chip enable", sram_addr, p_addr);
            setup_cnt = (!sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe) ? setup_cnt + 1 : 0;
            wlo_cnt   = !sram_we_n ? wlo_cnt + 1 : 0;
            hold_cnt  = (sram_dq_oe && sram_we_n) ? hold_cnt + 1 : 0;
        end
        p_we = sram_we_n; p_ce = sram_ce_n; p_oe_drv = sram_dq_oe; p_addr = sram_addr;
    end

    // One access; returns read data, falling edge of rd_valid and of ready
    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] m, output logic [DW-1:0] rdat,
                        output int t_rv, output int t_rdy);
        int n;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        n = 1; t_rv = 0; rdat = '0;
        if (!wr) begin
            while (!rd_valid && n < 50) begin @(negedge clk); n++; end
            t_rv = n; rdat = rd_data;
        end
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
        t_rdy = n;
        if (wr) for (int i = 0; i < 2; i++)
            if (m[i]) begin
                logic [DW-1:0] w;
                w = ref_rd(int'(a));
                w[8*i +: 8] = d[8*i +: 8];
                refm[int'(a)] = w;
            end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] m);
        logic [DW-1:0] r; int tv, tr;
        xfer(1, a, d, m, r, tv, tr);
        chk(m == 0 ? "R9 zero-mask write ready" : "R2 write ready latency", tr,
            m == 0 ? 1 : TS + TW + TH + 1);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m);
        logic [DW-1:0] r, e; int tv, tr;
        e = ref_rd(int'(a)) & lane_mask(m);
        xfer(0, a, '0, m, r, tv, tr);
        chk(m == 0 ? "R9 zero-mask read data" : "R5 read data", r, e);
        chk(m == 0 ? "R9 zero-mask read valid" : "R5 read valid latency", tv, m == 0 ? 1 : TR + 1);
        chk(m == 0 ? "R9 zero-mask read ready" : "R8 read ready after turnaround", tr,
            m == 0 ? 1 : TR + TT + 1);
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        chk("R1 strobes in reset", {sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n}, 5'h1f);
        chk("R1 driver off in reset", sram_dq_oe, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 no read pulse after reset", rd_valid, 0);

        // Directed corner cases
        do_write(15'h0000, 16'h1234, 2'b11);
        do_read(15'h0000, 2'b11);
        do_write(15'h0000, 16'hABCD, 2'b01);          // R4 low byte only
        do_read(15'h0000, 2'b11);
        do_write(15'h7FFF, 16'hBEEF, 2'b10);          // R4 high byte only at top address
        do_read(15'h7FFF, 2'b11);
        do_read(15'h7FFF, 2'b01);
        ce_seen = 0;
        do_write(15'h0000, 16'hFFFF, 2'b00);
        chk("R9 zero-mask write left strobes high", ce_seen, 0);
        do_read(15'h0000, 2'b11);
        ce_seen = 0;
        do_read(15'h0000, 2'b00);
        chk("R9 zero-mask read left strobes high", ce_seen, 0);

        // Random traffic
        for (int k = 0; k < 150; k++) begin
            logic [AW-1:0] a;
            logic [1:0] m;
            a = AW'($urandom & 15) | (($urandom & 1) ? AW'(15'h7FF0) : '0);
            m = 2'($urandom);
            if ($urandom & 1) do_write(a, 16'($urandom), m);
            else              do_read(a, m);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule